// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block watches the bus writes a host makes to a parallel NOR-style flash and decides what mode the device is in. Each write carries a byte offset, a data word and a bus-width code. The low byte of the data is the command byte. The block scales the offset to a word offset and checks the multi-cycle key patterns. It then moves between plain read, identifier read, query-table read and the status modes that follow a program or an erase.

When a program or erase sequence completes, the block issues a one-cycle start pulse with the target address and data for the array engine. While the external erase engine reports busy, the block stays in a status mode and refuses every write. When busy drops, the block returns to read mode, or to the shortened command cycle if the bypass shortcut is in force.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `modeCode` is 0 (read) and `programStart` and `eraseStart` are low.
- R2: An unlock pair is command byte 0xAA at word offset 0x555 followed by 0x55 at word offset 0x2AA. Any mismatch returns to read mode, and the next command byte is then not recognised.
- R3: After an unlock pair, the command byte at word offset 0x555 selects the next mode. 0x90 gives identifier mode (`modeCode` 1), 0xA0 gives program setup (`modeCode` 2), 0x80 gives erase setup (`modeCode` 0) and 0x20 enables bypass. Any other byte, or any other offset, returns to read mode.
- R4: In program setup, the next write is taken as data even if it is 0xF0. One cycle after that write, `programStart` pulses for exactly one cycle, with `cmdAddr` equal to the byte offset and `cmdData` equal to the full data word. The block then returns to read mode.
- R5: Command byte 0x98 at word offset 0x55 enters query mode (`modeCode` 3), both from read mode and from identifier mode. Any write made in query mode returns to read mode.
- R6: Command byte 0xF0 returns to read mode and clears bypass from every state except program setup and erase in progress.
- R7: Erase setup needs a second unlock pair. Then 0x10 at word offset 0x555 pulses `eraseStart` with `eraseChip`=1 and `cmdAddr`=0. Alternatively, 0x30 at any offset pulses `eraseStart` with `eraseChip`=0 and `cmdAddr` equal to the byte offset rounded down to the sector. Any other write returns to read mode. While the erase runs, `modeCode` is 2.
- R8: With bypass enabled, the command cycle skips the unlock pair and the offset check. After a program the block goes back to that command cycle. A write of 0x90 followed by a write of 0x00 leaves bypass and returns to read mode.
- R9: While `eraseBusy` is high, every write is ignored and the mode is held. During an erase this includes 0xF0.
- R10: When `eraseBusy` falls during an erase, the block returns to read mode, or to the bypass command cycle if bypass is enabled.
- R11: The word offset is the byte offset masked to the sector size (64 KiB by default), then shifted right by `busWidth` (0 for 8-bit, 1 for 16-bit, 2 or 3 for 32-bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe, one cycle per write |
| wrByteOff | input | ADDR_W | Byte offset of the write within the device |
| wrData | input | DATA_W | Write data; the low byte is the command byte |
| busWidth | input | 2 | Bus width code: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| eraseBusy | input | 1 | High while the erase engine is working |
| modeCode | output | 2 | 0 read, 1 identifier, 2 status, 3 query |
| programStart | output | 1 | One-cycle program request |
| eraseStart | output | 1 | One-cycle erase request |
| eraseChip | output | 1 | With eraseStart: 1 = whole chip, 0 = one sector |
| cmdAddr | output | ADDR_W | Address carried with a start pulse |
| cmdData | output | DATA_W | Data carried with a start pulse |

## Verification
The hardest situation to reach from the ports is a bypass session that runs a full erase and then comes back from busy straight into the short command cycle. The stimulus first enables bypass. It then issues erase setup and a second unlock pair, starts a sector erase, and raises and drops `eraseBusy`. Finally it issues a bare program command with no unlock. The program command must show status mode at once, and the data write after it must produce the program pulse. A second run aims rejected writes at the erase-busy window, including 0xF0, and confirms the status mode does not move.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_UNLK1,
    S_CMD,
    S_PROG,
    S_AUTO,
    S_CFI,
    S_EUNLK0,
    S_EUNLK1,
    S_ECMD,
    S_ERASING
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_READ   = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_STATUS = 2'd2,
    MODE_QUERY  = 2'd3
  } mode_e;

  typedef struct packed {
    logic keyAddrA;
    logic keyAddrB;
    logic queryAddr;
  } addr_match_t;

  typedef struct packed {
    logic progGo;
    logic eraseGo;
    logic eraseWhole;
  } strobe_t;

  localparam logic [11:0] KEY_ADDR_A  = 12'h555;
  localparam logic [11:0] KEY_ADDR_B  = 12'h2AA;
  localparam logic [11:0] QUERY_ADDR  = 12'h055;

  localparam logic [7:0] KEY_DATA_A   = 8'hAA;
  localparam logic [7:0] KEY_DATA_B   = 8'h55;
  localparam logic [7:0] OP_ERASE_SET = 8'h80;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_PROGRAM   = 8'hA0;
  localparam logic [7:0] OP_BYPASS    = 8'h20;
  localparam logic [7:0] OP_QUERY     = 8'h98;
  localparam logic [7:0] OP_RESET     = 8'hF0;
  localparam logic [7:0] OP_CHIP_ERS  = 8'h10;
  localparam logic [7:0] OP_SECT_ERS  = 8'h30;

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 32,
  parameter int SECTOR_BYTES = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrByteOff,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        busWidth,
  input  strobe_t           strobe,
  output addr_match_t       match,
  output logic              programStart,
  output logic              eraseStart,
  output logic              eraseChip,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData
);

  localparam int SEC_W = $clog2(SECTOR_BYTES);

  logic [SEC_W-1:0]  inSector;
  logic [SEC_W-1:0]  wordOff;
  logic [ADDR_W-1:0] sectorBase;

  assign inSector   = wrByteOff[SEC_W-1:0];
  assign sectorBase = {wrByteOff[ADDR_W-1:SEC_W], {SEC_W{1'b0}}};

  // Offset scaling by bus width (R11)
  always_comb begin
    case (busWidth)
      2'd0:    wordOff = inSector;
      2'd1:    wordOff = inSector >> 1;
      default: wordOff = inSector >> 2;
    endcase
  end

  assign match.keyAddrA  = (wordOff == SEC_W'(KEY_ADDR_A));
  assign match.keyAddrB  = (wordOff == SEC_W'(KEY_ADDR_B));
  assign match.queryAddr = (wordOff == SEC_W'(QUERY_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      programStart <= 1'b0;
      eraseStart   <= 1'b0;
      eraseChip    <= 1'b0;
      cmdAddr      <= '0;
      cmdData      <= '0;
    end else begin
      programStart <= strobe.progGo;
      eraseStart   <= strobe.eraseGo;
      if (strobe.progGo) begin
        cmdAddr <= wrByteOff;
        cmdData <= wrData;
      end else if (strobe.eraseGo) begin
        eraseChip <= strobe.eraseWhole;
        cmdAddr   <= strobe.eraseWhole ? '0 : sectorBase;
        cmdData   <= wrData;
      end
    end
  end

  AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    programStart |=> !programStart);  // R4
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> !programStart);  // R7
  AST_SECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (eraseStart && !eraseChip) |-> (cmdAddr[SEC_W-1:0] == '0));  // R7

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrCmd,
  input  logic        eraseBusy,
  input  addr_match_t match,
  output strobe_t     strobe,
  output logic [1:0]  modeCode
);

  seq_state_e state, nState;
  logic       bypass, nBypass;
  logic       busyQ;
  logic       accept;

  assign accept = wrEn && !eraseBusy;

  always_comb begin
    nState  = state;
    nBypass = bypass;
    strobe  = '0;
    if (state == S_ERASING) begin
      if (busyQ && !eraseBusy) nState = bypass ? S_CMD : S_IDLE;
    end else if (accept) begin
      if (wrCmd == OP_RESET && state != S_PROG) begin
        nState  = S_IDLE;
        nBypass = 1'b0;
      end else begin
        nState  = S_IDLE;
        nBypass = 1'b0;
        case (state)
          S_IDLE: begin
            if (match.queryAddr && wrCmd == OP_QUERY)       nState = S_CFI;
            else if (match.keyAddrA && wrCmd == KEY_DATA_A) nState = S_UNLK1;
          end
          S_UNLK1: begin
            if (match.keyAddrB && wrCmd == KEY_DATA_B) begin
              nState  = S_CMD;
              nBypass = bypass;
            end
          end
          S_CMD: begin
            if (bypass || match.keyAddrA) begin
              nBypass = bypass;
              case (wrCmd)
                OP_BYPASS:    begin nState = S_CMD; nBypass = 1'b1; end
                OP_ERASE_SET: nState = S_EUNLK0;
                OP_IDENT:     nState = S_AUTO;
                OP_PROGRAM:   nState = S_PROG;
                default:      begin nState = S_IDLE; nBypass = 1'b0; end
              endcase
            end
          end
          S_PROG: begin
            strobe.progGo = 1'b1;
            nBypass       = bypass;
            nState        = bypass ? S_CMD : S_IDLE;
          end
          S_AUTO: begin
            if (match.queryAddr && wrCmd == OP_QUERY) begin
              nState  = S_CFI;
              nBypass = bypass;
            end
          end
          S_EUNLK0: begin
            if (match.keyAddrA && wrCmd == KEY_DATA_A) begin
              nState  = S_EUNLK1;
              nBypass = bypass;
            end
          end
          S_EUNLK1: begin
            if (match.keyAddrB && wrCmd == KEY_DATA_B) begin
              nState  = S_ECMD;
              nBypass = bypass;
            end
          end
          S_ECMD: begin
            if (wrCmd == OP_CHIP_ERS && match.keyAddrA) begin
              strobe.eraseGo    = 1'b1;
              strobe.eraseWhole = 1'b1;
              nState            = S_ERASING;
              nBypass           = bypass;
            end else if (wrCmd == OP_SECT_ERS) begin
              strobe.eraseGo = 1'b1;
              nState         = S_ERASING;
              nBypass        = bypass;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bypass <= 1'b0;
      busyQ  <= 1'b0;
    end else begin
      state  <= nState;
      bypass <= nBypass;
      busyQ  <= eraseBusy;
    end
  end

  always_comb begin
    case (state)
      S_AUTO:            modeCode = MODE_IDENT;
      S_CFI:             modeCode = MODE_QUERY;
      S_PROG, S_ERASING: modeCode = MODE_STATUS;
      default:           modeCode = MODE_READ;
    endcase
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    eraseBusy |=> ($stable(state) && $stable(bypass)));  // R9
  AST_PROG_LEAVES: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PROG && accept) |=> (state == S_IDLE || state == S_CMD));  // R4
  AST_QUERY_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CFI && accept) |=> (state == S_IDLE));  // R5
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (accept && wrCmd == OP_RESET && state != S_PROG && state != S_ERASING)
      |=> (state == S_IDLE && !bypass));  // R6

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 32,
  parameter int SECTOR_BYTES = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrByteOff,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        busWidth,
  input  logic              eraseBusy,
  output logic [1:0]        modeCode,
  output logic              programStart,
  output logic              eraseStart,
  output logic              eraseChip,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData
);

  addr_match_t match;
  strobe_t     strobe;

  flash_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrCmd    (wrData[7:0]),
    .eraseBusy(eraseBusy),
    .match    (match),
    .strobe   (strobe),
    .modeCode (modeCode)
  );

  flash_seq_dp #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SECTOR_BYTES(SECTOR_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrByteOff   (wrByteOff),
    .wrData      (wrData),
    .busWidth    (busWidth),
    .strobe      (strobe),
    .match       (match),
    .programStart(programStart),
    .eraseStart  (eraseStart),
    .eraseChip   (eraseChip),
    .cmdAddr     (cmdAddr),
    .cmdData     (cmdData)
  );

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int NVEC = 43;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrByteOff = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [1:0]        busWidth = '0;
  logic              eraseBusy = 1'b0;
  logic [1:0]        modeCode;
  logic              programStart, eraseStart, eraseChip;
  logic [ADDR_W-1:0] cmdAddr;
  logic [DATA_W-1:0] cmdData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  flash_cmd_seq u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByteOff(wrByteOff),
    .wrData(wrData), .busWidth(busWidth), .eraseBusy(eraseBusy),
    .modeCode(modeCode), .programStart(programStart), .eraseStart(eraseStart),
    .eraseChip(eraseChip), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {req[3:0], byteOff[19:0], data[7:0], width[1:0], expMode[1:0], expProg}
  localparam logic [36:0] VEC [NVEC] = '{
    {4'd2,  20'h00555, 8'hAA, 2'd0, 2'd0, 1'b0},
    {4'd2,  20'h002AA, 8'h55, 2'd0, 2'd0, 1'b0},
    {4'd3,  20'h00555, 8'h90, 2'd0, 2'd1, 1'b0},
    {4'd6,  20'h00000, 8'hF0, 2'd0, 2'd0, 1'b0},
    {4'd5,  20'h00055, 8'h98, 2'd0, 2'd3, 1'b0},
    {4'd5,  20'h00123, 8'h00, 2'd0, 2'd0, 1'b0},
    {4'd11, 20'h00AAA, 8'hAA, 2'd1, 2'd0, 1'b0},
    {4'd11, 20'h00554, 8'h55, 2'd1, 2'd0, 1'b0},
    {4'd11, 20'h00AAA, 8'hA0, 2'd1, 2'd2, 1'b0},
    {4'd4,  20'h01000, 8'h3C, 2'd1, 2'd0, 1'b1},
    {4'd2,  20'h00555, 8'hAA, 2'd0, 2'd0, 1'b0},
    {4'd2,  20'h002AA, 8'h56, 2'd0, 2'd0, 1'b0},
    {4'd2,  20'h00555, 8'h90, 2'd0, 2'd0, 1'b0},
    {4'd11, 20'h01554, 8'hAA, 2'd2, 2'd0, 1'b0},
    {4'd11, 20'h00AA8, 8'h55, 2'd2, 2'd0, 1'b0},
    {4'd11, 20'h01554, 8'h90, 2'd2, 2'd1, 1'b0},
    {4'd5,  20'h000AA, 8'h98, 2'd1, 2'd3, 1'b0},
    {4'd6,  20'h00000, 8'hF0, 2'd0, 2'd0, 1'b0},
    {4'd8,  20'h00555, 8'hAA, 2'd0, 2'd0, 1'b0},
    {4'd8,  20'h002AA, 8'h55, 2'd0, 2'd0, 1'b0},
    {4'd8,  20'h00555, 8'h20, 2'd0, 2'd0, 1'b0},
    {4'd8,  20'h00777, 8'hA0, 2'd0, 2'd2, 1'b0},
    {4'd8,  20'h02000, 8'h12, 2'd0, 2'd0, 1'b1},
    {4'd8,  20'h00010, 8'hA0, 2'd0, 2'd2, 1'b0},
    {4'd8,  20'h03000, 8'h34, 2'd0, 2'd0, 1'b1},
    {4'd8,  20'h00000, 8'h90, 2'd0, 2'd1, 1'b0},
    {4'd8,  20'h00000, 8'h00, 2'd0, 2'd0, 1'b0},
    {4'd8,  20'h00000, 8'hA0, 2'd0, 2'd0, 1'b0},
    {4'd8,  20'h02000, 8'h77, 2'd0, 2'd0, 1'b0},
    {4'd4,  20'h00555, 8'hAA, 2'd0, 2'd0, 1'b0},
    {4'd4,  20'h002AA, 8'h55, 2'd0, 2'd0, 1'b0},
    {4'd4,  20'h00555, 8'hA0, 2'd0, 2'd2, 1'b0},
    {4'd4,  20'h04000, 8'hF0, 2'd0, 2'd0, 1'b1},
    {4'd3,  20'h00555, 8'hAA, 2'd0, 2'd0, 1'b0},
    {4'd3,  20'h002AA, 8'h55, 2'd0, 2'd0, 1'b0},
    {4'd3,  20'h00555, 8'h77, 2'd0, 2'd0, 1'b0},
    {4'd3,  20'h00555, 8'hAA, 2'd0, 2'd0, 1'b0},
    {4'd3,  20'h002AA, 8'h55, 2'd0, 2'd0, 1'b0},
    {4'd3,  20'h00554, 8'h90, 2'd0, 2'd0, 1'b0},
    {4'd11, 20'h10555, 8'hAA, 2'd0, 2'd0, 1'b0},
    {4'd11, 20'h102AA, 8'h55, 2'd0, 2'd0, 1'b0},
    {4'd11, 20'h10555, 8'h90, 2'd0, 2'd1, 1'b0},
    {4'd6,  20'h00000, 8'hF0, 2'd0, 2'd0, 1'b0}
  };

  function automatic string reqName(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] off, input logic [DATA_W-1:0] d,
                         input logic [1:0] w);
    @(negedge clk);
    wrByteOff = off;
    wrData    = d;
    busWidth  = w;
    wrEn      = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic unlockPair();
    doWrite(20'h00555, 32'hAA, 2'd0);
    doWrite(20'h002AA, 32'h55, 2'd0);
  endtask

  task automatic busyPulse();
    @(negedge clk); eraseBusy = 1'b1;
    repeat (3) @(negedge clk);
    eraseBusy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "mode", 32'(modeCode), 32'd0);
    check("R1", "programStart", 32'(programStart), 32'd0);
    check("R1", "eraseStart", 32'(eraseStart), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [36:0] v;
      v = VEC[i];
      doWrite(v[32:13], 32'(v[12:5]), v[4:3]);
      check(reqName(int'(v[36:33])), "mode", 32'(modeCode), 32'(v[2:1]));
      check(reqName(int'(v[36:33])), "programStart", 32'(programStart), 32'(v[0]));
      check(reqName(int'(v[36:33])), "eraseStart", 32'(eraseStart), 32'd0);
      if (v[0]) begin
        check(reqName(int'(v[36:33])), "cmdAddr", 32'(cmdAddr), 32'(v[32:13]));
        check(reqName(int'(v[36:33])), "cmdData", cmdData, 32'(v[12:5]));
      end
    end

    // R7 sector erase, R9 writes ignored while busy, R10 return on busy fall
    unlockPair();
    doWrite(20'h00555, 32'h80, 2'd0);
    check("R7", "erase setup mode", 32'(modeCode), 32'd0);
    unlockPair();
    doWrite(20'h12345, 32'h30, 2'd0);
    check("R7", "eraseStart", 32'(eraseStart), 32'd1);
    check("R7", "eraseChip", 32'(eraseChip), 32'd0);
    check("R7", "sector cmdAddr", 32'(cmdAddr), 32'h10000);
    check("R7", "erase mode", 32'(modeCode), 32'd2);
    @(negedge clk); eraseBusy = 1'b1;
    doWrite(20'h00555, 32'hAA, 2'd0);
    check("R9", "mode with busy", 32'(modeCode), 32'd2);
    doWrite(20'h00000, 32'hF0, 2'd0);
    check("R9", "reset ignored in erase", 32'(modeCode), 32'd2);
    check("R9", "no pulse", 32'(eraseStart | programStart), 32'd0);
    eraseBusy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10", "read after busy", 32'(modeCode), 32'd0);
    unlockPair();
    doWrite(20'h00555, 32'h90, 2'd0);
    check("R10", "usable after erase", 32'(modeCode), 32'd1);
    doWrite(20'h00000, 32'hF0, 2'd0);

    // R7 chip erase
    unlockPair();
    doWrite(20'h00555, 32'h80, 2'd0);
    unlockPair();
    doWrite(20'h00555, 32'h5A10, 2'd0);
    check("R7", "chip eraseStart", 32'(eraseStart), 32'd1);
    check("R7", "chip eraseChip", 32'(eraseChip), 32'd1);
    check("R7", "chip cmdAddr", 32'(cmdAddr), 32'd0);
    busyPulse();
    check("R10", "read after chip erase", 32'(modeCode), 32'd0);

    // R7 chip erase at wrong offset rejected
    unlockPair();
    doWrite(20'h00555, 32'h80, 2'd0);
    unlockPair();
    doWrite(20'h00554, 32'h10, 2'd0);
    check("R7", "bad chip erase pulse", 32'(eraseStart), 32'd0);
    check("R7", "bad chip erase mode", 32'(modeCode), 32'd0);

    // R8 and R10: erase inside bypass returns to short command cycle
    unlockPair();
    doWrite(20'h00555, 32'h20, 2'd0);
    doWrite(20'h00000, 32'h80, 2'd0);
    unlockPair();
    doWrite(20'h00000, 32'h30, 2'd0);
    check("R8", "bypass erase", 32'(eraseStart), 32'd1);
    busyPulse();
    doWrite(20'h00000, 32'hA0, 2'd0);
    check("R10", "bypass cmd after erase", 32'(modeCode), 32'd2);
    doWrite(20'h00500, 32'hCAFE0099, 2'd0);
    check("R8", "bypass program pulse", 32'(programStart), 32'd1);
    check("R8", "bypass program data", cmdData, 32'hCAFE0099);
    doWrite(20'h00000, 32'hF0, 2'd0);
    doWrite(20'h00000, 32'hA0, 2'd0);
    check("R6", "bypass cleared by reset", 32'(modeCode), 32'd0);

    // R9 busy holds off commands in read mode
    @(negedge clk); eraseBusy = 1'b1;
    unlockPair();
    doWrite(20'h00555, 32'h90, 2'd0);
    check("R9", "ident blocked by busy", 32'(modeCode), 32'd0);
    @(negedge clk); eraseBusy = 1'b0;
    @(negedge clk);
    doWrite(20'h00555, 32'h90, 2'd0);
    check("R9", "no unlock retained", 32'(modeCode), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule